// File: doc/BRIEF.md
# Interrupt Arbitration and Trap Routing Unit

This block sits beside a processor's control-status state and decides, every cycle, whether the hart traps and where it goes. It takes the vector of pending interrupt lines, the current privilege (user, supervisor or machine), the global interrupt enables, and the interrupt and exception delegation masks. From these it selects at most one interrupt. Machine-level candidates are considered before delegated supervisor candidates. Within the chosen group, a fixed class order applies, and the lowest set bit of the winning class gives the cause number.

A trap is either a selected interrupt or an exception request presented with its cause and fault value. For each trap the unit produces a single trap strobe, the next program counter, the target privilege, the cause word, the EPC and TVAL values to be written, and the new enable, previous-enable and previous-privilege fields for both privilege stacks. The surrounding core latches these values on the strobe. All trap outputs are combinational from the inputs, so the decision applies in the same cycle the request appears. An input marks that the core is halted in debug mode; while it is high, no interrupt is taken.

Privilege encoding used on all ports: 0 = user, 1 = supervisor, 3 = machine.

Top module: `trap_unit`

## Requirements
- R1: When neither an interrupt is selected nor an exception is requested, trap_o is 0. In that case trap_pc_o, trap_cause_o, trap_epc_o and trap_tval_o are 0, priv_o equals priv_i, and every status output equals its matching status input.
- R2: A pending line whose interrupt-delegation bit is clear is a machine candidate. It is enabled when priv_i is below machine, or when priv_i is machine and m_ie_i is 1. An enabled machine candidate traps to machine mode.
- R3: A pending line whose delegation bit is set is considered only when there is no enabled machine candidate. It is enabled when priv_i is user, or when priv_i is supervisor and s_ie_i is 1. It is never taken while priv_i is machine.
- R4: Among the candidates, a class order applies. First come lines 12 and above, then external lines (9, 11), then software lines (1, 3), then timer lines (5, 7). The lowest set line in the winning class is taken. Lines 0, 2, 4, 6, 8 and 10 are never taken.
- R5: An interrupt cause word is the line number with bit XLEN-1 set. An exception cause word is exc_cause_i unchanged.
- R6: While dbg_mode_i is 1, no interrupt is taken. An exception request is still routed normally.
- R7: When an interrupt and an exception request occur in the same cycle, the interrupt wins. trap_epc_o is epc_i for every trap. trap_tval_o is 0 for an interrupt and exc_tval_i for an exception.
- R8: A trap goes to supervisor mode when all of the following hold: priv_i is user or supervisor, the cause number is below XLEN, and the matching delegation bit is set. The interrupt mask applies to interrupts and the exception mask to exceptions. In every other case the trap goes to machine mode.
- R9: On a supervisor trap, trap_pc_o is s_tvec_i unchanged, s_pie_o takes s_ie_i, s_pp_o takes priv_i bit 0, s_ie_o is 0 and priv_o is 1. The machine fields pass through unchanged.
- R10: On a machine trap, m_pie_o takes m_ie_i, m_pp_o takes priv_i, m_ie_o is 0 and priv_o is 3. The supervisor fields pass through unchanged.
- R11: For a machine trap, the base address is m_tvec_i with bit 0 cleared. When m_tvec_i bit 0 is 1 and the trap is an interrupt, trap_pc_o is the base plus 4 times the line number. Otherwise trap_pc_o is the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (sampling for the embedded checks) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pend_i | input | IRQW | Pending interrupt lines |
| priv_i | input | 2 | Current privilege |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| m_pie_i | input | 1 | Machine previous-enable field |
| s_pie_i | input | 1 | Supervisor previous-enable field |
| m_pp_i | input | 2 | Machine previous-privilege field |
| s_pp_i | input | 1 | Supervisor previous-privilege field |
| irq_deleg_i | input | IRQW | Interrupt delegation mask |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| dbg_mode_i | input | 1 | Core halted in debug mode |
| exc_req_i | input | 1 | Exception request |
| exc_cause_i | input | XLEN | Exception cause number |
| exc_tval_i | input | XLEN | Exception fault value |
| epc_i | input | XLEN | PC of the interrupted or faulting instruction |
| s_tvec_i | input | XLEN | Supervisor trap vector |
| m_tvec_i | input | XLEN | Machine trap vector, bit 0 selects vectored mode |
| trap_o | output | 1 | Trap strobe |
| trap_irq_o | output | 1 | Trap is an interrupt |
| trap_to_s_o | output | 1 | Trap targets supervisor mode |
| trap_pc_o | output | XLEN | Next program counter |
| trap_cause_o | output | XLEN | Cause word to write |
| trap_epc_o | output | XLEN | EPC value to write |
| trap_tval_o | output | XLEN | TVAL value to write |
| priv_o | output | 2 | Privilege after the trap |
| m_ie_o | output | 1 | New machine enable |
| m_pie_o | output | 1 | New machine previous-enable |
| m_pp_o | output | 2 | New machine previous-privilege |
| s_ie_o | output | 1 | New supervisor enable |
| s_pie_o | output | 1 | New supervisor previous-enable |
| s_pp_o | output | 1 | New supervisor previous-privilege |

## Verification
An enabled interrupt and an exception request can arrive in the same cycle. They contend for the single trap strobe and for the cause, TVAL and vector outputs. The bench provokes this with a machine-external line pending, vectored mode on and an exception carrying a non-zero fault value. It then checks three things: the interrupt cause is reported, TVAL is zero and the PC is vectored by the interrupt line rather than by the exception cause. A second overlap places a delegated and an undelegated line pending together at user level, and the bench expects the machine line to win even though it sits in a lower class.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // interrupt line positions
  localparam int unsigned LINE_SSW = 1;
  localparam int unsigned LINE_MSW = 3;
  localparam int unsigned LINE_STM = 5;
  localparam int unsigned LINE_MTM = 7;
  localparam int unsigned LINE_SEX = 9;
  localparam int unsigned LINE_MEX = 11;
  localparam int unsigned LINE_HI  = 12;

  typedef enum logic [1:0] {
    CLS_HI  = 2'd0,
    CLS_EXT = 2'd1,
    CLS_SW  = 2'd2,
    CLS_TM  = 2'd3
  } irq_class_e;
endpackage

// File: rtl/lsb_pick.sv
module lsb_pick #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          hit_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign hit_o = |vec_i;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned IRQW = 16,
  parameter int unsigned IW   = $clog2(IRQW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IRQW-1:0] pend_i,
  input  logic [IRQW-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            m_ie_i,
  input  logic            s_ie_i,
  input  logic            dbg_i,
  output logic            take_o,
  output logic [IW-1:0]   idx_o
);
  logic [IRQW-1:0] hi_m, ext_m, sw_m, tm_m, valid_m;

  // class masks per line
  for (genvar g = 0; g < IRQW; g++) begin : g_cls
    assign hi_m[g]  = (g >= LINE_HI);
    assign ext_m[g] = (g == LINE_SEX) || (g == LINE_MEX);
    assign sw_m[g]  = (g == LINE_SSW) || (g == LINE_MSW);
    assign tm_m[g]  = (g == LINE_STM) || (g == LINE_MTM);
  end
  assign valid_m = hi_m | ext_m | sw_m | tm_m;

  priv_e priv;
  assign priv = priv_e'(priv_i);

  logic m_en, s_en;
  assign m_en = (priv != PRIV_M) || m_ie_i;
  assign s_en = (priv == PRIV_U) || ((priv == PRIV_S) && s_ie_i);

  logic [IRQW-1:0] m_cand, s_cand, cand, win;
  assign m_cand = pend_i & valid_m & ~deleg_i & {IRQW{m_en}};
  assign s_cand = pend_i & valid_m &  deleg_i & {IRQW{s_en}};
  assign cand   = dbg_i ? '0 : ((|m_cand) ? m_cand : s_cand);

  irq_class_e cls;
  always_comb begin
    if      (|(cand & hi_m))  cls = CLS_HI;
    else if (|(cand & ext_m)) cls = CLS_EXT;
    else if (|(cand & sw_m))  cls = CLS_SW;
    else                      cls = CLS_TM;
  end

  always_comb begin
    unique case (cls)
      CLS_HI:  win = cand & hi_m;
      CLS_EXT: win = cand & ext_m;
      CLS_SW:  win = cand & sw_m;
      default: win = cand & tm_m;
    endcase
  end

  lsb_pick #(.W(IRQW), .IW(IW)) u_pick (
    .vec_i (win),
    .idx_o (idx_o),
    .hit_o (take_o)
  );

  assert_dbg_blocks_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |-> !take_o);
  assert_taken_line_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> pend_i[idx_o]);
  assert_no_deleg_in_m_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && priv_i == 2'd3) |-> !deleg_i[idx_o]);
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IRQW = 16,
  parameter int unsigned IW   = $clog2(IRQW),
  parameter int unsigned LX   = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_take_i,
  input  logic [IW-1:0]   irq_idx_i,
  input  logic            exc_req_i,
  input  logic [XLEN-1:0] exc_cause_i,
  input  logic [XLEN-1:0] exc_tval_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [1:0]      priv_i,
  input  logic [IRQW-1:0] irq_deleg_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] s_tvec_i,
  input  logic [XLEN-1:0] m_tvec_i,
  input  logic            m_ie_i,
  input  logic            m_pie_i,
  input  logic [1:0]      m_pp_i,
  input  logic            s_ie_i,
  input  logic            s_pie_i,
  input  logic            s_pp_i,
  output logic            trap_o,
  output logic            irq_o,
  output logic            to_s_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] tval_o,
  output logic [1:0]      priv_o,
  output logic            m_ie_o,
  output logic            m_pie_o,
  output logic [1:0]      m_pp_o,
  output logic            s_ie_o,
  output logic            s_pie_o,
  output logic            s_pp_o
);
  logic [XLEN-1:0] num, m_base, m_off;
  logic            in_range, deleg_bit, below_m;

  assign trap_o  = irq_take_i | exc_req_i;
  assign irq_o   = irq_take_i;
  assign num     = irq_take_i ? XLEN'(irq_idx_i) : exc_cause_i;
  assign in_range = (num < XLEN'(XLEN));
  assign below_m = (priv_i == PRIV_U) || (priv_i == PRIV_S);

  always_comb begin
    if (irq_take_i)    deleg_bit = irq_deleg_i[irq_idx_i];
    else if (in_range) deleg_bit = exc_deleg_i[exc_cause_i[LX-1:0]];
    else               deleg_bit = 1'b0;
  end

  assign to_s_o = trap_o && below_m && in_range && deleg_bit;

  // vectored entry only for machine-mode interrupts
  assign m_base = {m_tvec_i[XLEN-1:1], 1'b0};
  assign m_off  = (m_tvec_i[0] && irq_take_i) ? (num << 2) : '0;

  always_comb begin
    pc_o    = '0;
    cause_o = '0;
    epc_o   = '0;
    tval_o  = '0;
    priv_o  = priv_i;
    m_ie_o  = m_ie_i;
    m_pie_o = m_pie_i;
    m_pp_o  = m_pp_i;
    s_ie_o  = s_ie_i;
    s_pie_o = s_pie_i;
    s_pp_o  = s_pp_i;
    if (trap_o) begin
      cause_o = irq_take_i ? {1'b1, num[XLEN-2:0]} : exc_cause_i;
      epc_o   = epc_i;
      tval_o  = irq_take_i ? '0 : exc_tval_i;
      if (to_s_o) begin
        pc_o    = s_tvec_i;
        priv_o  = PRIV_S;
        s_pie_o = s_ie_i;
        s_pp_o  = priv_i[0];
        s_ie_o  = 1'b0;
      end else begin
        pc_o    = m_base + m_off;
        priv_o  = PRIV_M;
        m_pie_o = m_ie_i;
        m_pp_o  = priv_i;
        m_ie_o  = 1'b0;
      end
    end
  end

  assert_s_target_below_m_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_s_o |-> (priv_i != 2'd3));
  assert_irq_cause_msb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cause_o[XLEN-1]);
  assert_m_trap_stack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !to_s_o) |-> (!m_ie_o && m_pie_o == m_ie_i && priv_o == 2'd3 && s_ie_o == s_ie_i));
  assert_s_trap_stack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_s_o |-> (!s_ie_o && s_pie_o == s_ie_i && pc_o == s_tvec_i && m_ie_o == m_ie_i));
  assert_idle_passthrough_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (priv_o == priv_i && pc_o == '0 && cause_o == '0));
  assert_irq_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && exc_req_i) |-> (tval_o == '0));
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IRQW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IRQW-1:0] irq_pend_i,
  input  logic [1:0]      priv_i,
  input  logic            m_ie_i,
  input  logic            s_ie_i,
  input  logic            m_pie_i,
  input  logic            s_pie_i,
  input  logic [1:0]      m_pp_i,
  input  logic            s_pp_i,
  input  logic [IRQW-1:0] irq_deleg_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic            dbg_mode_i,
  input  logic            exc_req_i,
  input  logic [XLEN-1:0] exc_cause_i,
  input  logic [XLEN-1:0] exc_tval_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] s_tvec_i,
  input  logic [XLEN-1:0] m_tvec_i,
  output logic            trap_o,
  output logic            trap_irq_o,
  output logic            trap_to_s_o,
  output logic [XLEN-1:0] trap_pc_o,
  output logic [XLEN-1:0] trap_cause_o,
  output logic [XLEN-1:0] trap_epc_o,
  output logic [XLEN-1:0] trap_tval_o,
  output logic [1:0]      priv_o,
  output logic            m_ie_o,
  output logic            m_pie_o,
  output logic [1:0]      m_pp_o,
  output logic            s_ie_o,
  output logic            s_pie_o,
  output logic            s_pp_o
);
  localparam int unsigned IW = $clog2(IRQW);
  localparam int unsigned LX = $clog2(XLEN);

  logic          irq_take;
  logic [IW-1:0] irq_idx;

  irq_arbiter #(.IRQW(IRQW), .IW(IW)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (irq_pend_i),
    .deleg_i (irq_deleg_i),
    .priv_i  (priv_i),
    .m_ie_i  (m_ie_i),
    .s_ie_i  (s_ie_i),
    .dbg_i   (dbg_mode_i),
    .take_o  (irq_take),
    .idx_o   (irq_idx)
  );

  trap_router #(.XLEN(XLEN), .IRQW(IRQW), .IW(IW), .LX(LX)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_take_i  (irq_take),
    .irq_idx_i   (irq_idx),
    .exc_req_i   (exc_req_i),
    .exc_cause_i (exc_cause_i),
    .exc_tval_i  (exc_tval_i),
    .epc_i       (epc_i),
    .priv_i      (priv_i),
    .irq_deleg_i (irq_deleg_i),
    .exc_deleg_i (exc_deleg_i),
    .s_tvec_i    (s_tvec_i),
    .m_tvec_i    (m_tvec_i),
    .m_ie_i      (m_ie_i),
    .m_pie_i     (m_pie_i),
    .m_pp_i      (m_pp_i),
    .s_ie_i      (s_ie_i),
    .s_pie_i     (s_pie_i),
    .s_pp_i      (s_pp_i),
    .trap_o      (trap_o),
    .irq_o       (trap_irq_o),
    .to_s_o      (trap_to_s_o),
    .pc_o        (trap_pc_o),
    .cause_o     (trap_cause_o),
    .epc_o       (trap_epc_o),
    .tval_o      (trap_tval_o),
    .priv_o      (priv_o),
    .m_ie_o      (m_ie_o),
    .m_pie_o     (m_pie_o),
    .m_pp_o      (m_pp_o),
    .s_ie_o      (s_ie_o),
    .s_pie_o     (s_pie_o),
    .s_pp_o      (s_pp_o)
  );

  assert_debug_exc_routed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_i && exc_req_i) |-> (trap_o && !trap_irq_o));
endmodule

// File: tb/sim_trap_unit.sv
`timescale 1ns/1ps
module sim_trap_unit;
  localparam int XLEN = 32;
  localparam int IRQW = 16;

  typedef struct packed {
    logic [15:0] pend;
    logic [1:0]  priv;
    logic        m_ie;
    logic        s_ie;
    logic        m_pie;
    logic        s_pie;
    logic [1:0]  m_pp;
    logic        s_pp;
    logic [15:0] ideleg;
    logic [31:0] edeleg;
    logic        dbg;
    logic        exc;
    logic [31:0] ecause;
    logic [31:0] etval;
    logic [31:0] epc;
    logic [31:0] svec;
    logic [31:0] mvec;
  } stim_t;

  typedef struct packed {
    logic        trap;
    logic        irq;
    logic        to_s;
    logic [31:0] pc;
    logic [31:0] cause;
    logic [31:0] epc;
    logic [31:0] tval;
    logic [1:0]  priv;
    logic        mie;
    logic        mpie;
    logic [1:0]  mpp;
    logic        sie;
    logic        spie;
    logic        spp;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  stim_t cur;
  exp_t  act;
  exp_t  exq[$];
  string tagq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  logic            trap, tirq, tos, mie, mpie, sie, spie, spp;
  logic [31:0]     tpc, tcause, tepc, ttval;
  logic [1:0]      tpriv, mpp;

  trap_unit #(.XLEN(XLEN), .IRQW(IRQW)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .irq_pend_i   (cur.pend),
    .priv_i       (cur.priv),
    .m_ie_i       (cur.m_ie),
    .s_ie_i       (cur.s_ie),
    .m_pie_i      (cur.m_pie),
    .s_pie_i      (cur.s_pie),
    .m_pp_i       (cur.m_pp),
    .s_pp_i       (cur.s_pp),
    .irq_deleg_i  (cur.ideleg),
    .exc_deleg_i  (cur.edeleg),
    .dbg_mode_i   (cur.dbg),
    .exc_req_i    (cur.exc),
    .exc_cause_i  (cur.ecause),
    .exc_tval_i   (cur.etval),
    .epc_i        (cur.epc),
    .s_tvec_i     (cur.svec),
    .m_tvec_i     (cur.mvec),
    .trap_o       (trap),
    .trap_irq_o   (tirq),
    .trap_to_s_o  (tos),
    .trap_pc_o    (tpc),
    .trap_cause_o (tcause),
    .trap_epc_o   (tepc),
    .trap_tval_o  (ttval),
    .priv_o       (tpriv),
    .m_ie_o       (mie),
    .m_pie_o      (mpie),
    .m_pp_o       (mpp),
    .s_ie_o       (sie),
    .s_pie_o      (spie),
    .s_pp_o       (spp)
  );

  function automatic stim_t base();
    stim_t s = '0;
    s.priv = 2'd3;
    s.epc  = 32'h0000_1000;
    s.svec = 32'h0000_2000;
    s.mvec = 32'h0000_3000;
    return s;
  endfunction

  // R1: nothing changes
  function automatic exp_t idle(stim_t s);
    exp_t e = '0;
    e.priv = s.priv; e.mie = s.m_ie; e.mpie = s.m_pie; e.mpp = s.m_pp;
    e.sie = s.s_ie; e.spie = s.s_pie; e.spp = s.s_pp;
    return e;
  endfunction

  // R10 stack update
  function automatic exp_t m_trap(stim_t s, logic irq, logic [31:0] cause,
                                  logic [31:0] pc, logic [31:0] tval);
    exp_t e = idle(s);
    e.trap = 1'b1; e.irq = irq; e.to_s = 1'b0; e.pc = pc; e.cause = cause;
    e.epc = s.epc; e.tval = tval; e.priv = 2'd3;
    e.mie = 1'b0; e.mpie = s.m_ie; e.mpp = s.priv;
    return e;
  endfunction

  // R9 stack update
  function automatic exp_t s_trap(stim_t s, logic irq, logic [31:0] cause,
                                  logic [31:0] pc, logic [31:0] tval);
    exp_t e = idle(s);
    e.trap = 1'b1; e.irq = irq; e.to_s = 1'b1; e.pc = pc; e.cause = cause;
    e.epc = s.epc; e.tval = tval; e.priv = 2'd1;
    e.sie = 1'b0; e.spie = s.s_ie; e.spp = s.priv[0];
    return e;
  endfunction

  task automatic drive(input string tag, input stim_t s, input exp_t e);
    @(posedge clk);
    #1;
    cur = s;
    exq.push_back(e);
    tagq.push_back(tag);
  endtask

  assign act = '{trap: trap, irq: tirq, to_s: tos, pc: tpc, cause: tcause,
                 epc: tepc, tval: ttval, priv: tpriv, mie: mie, mpie: mpie,
                 mpp: mpp, sie: sie, spie: spie, spp: spp};

  // monitor: one result per cycle, compared at the falling edge
  always @(negedge clk) begin
    if (exq.size() > 0) begin
      exp_t  e;
      string t;
      e = exq.pop_front();
      t = tagq.pop_front();
      n_cmp++;
      if (act !== e) begin
        n_bad++;
        $display("FAIL %s: actual trap=%b irq=%b s=%b pc=%h cause=%h epc=%h tval=%h priv=%0d m=%b%b%0d s=%b%b%b | expected trap=%b irq=%b s=%b pc=%h cause=%h epc=%h tval=%h priv=%0d m=%b%b%0d s=%b%b%b",
                 t, act.trap, act.irq, act.to_s, act.pc, act.cause, act.epc, act.tval,
                 act.priv, act.mie, act.mpie, act.mpp, act.sie, act.spie, act.spp,
                 e.trap, e.irq, e.to_s, e.pc, e.cause, e.epc, e.tval,
                 e.priv, e.mie, e.mpie, e.mpp, e.sie, e.spie, e.spp);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    stim_t s;
    cur = base();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state and pass-through
    s = base();
    drive("R1 idle after reset", s, idle(s));
    s = base(); s.s_ie = 1; s.m_pie = 1; s.m_pp = 2'd1; s.s_pp = 1; s.priv = 2'd1;
    drive("R1 status pass-through", s, idle(s));

    // R2 machine enable
    s = base(); s.pend = 16'h0080;
    drive("R2 M-level, MIE off", s, idle(s));
    s = base(); s.m_ie = 1; s.pend = 16'h0080;
    drive("R2 R10 M-level, MIE on", s, m_trap(s, 1, 32'h8000_0007, 32'h3000, 0));
    s = base(); s.priv = 2'd0; s.pend = 16'h0008;
    drive("R2 user level ignores MIE", s, m_trap(s, 1, 32'h8000_0003, 32'h3000, 0));

    // R4 class order
    s = base(); s.m_ie = 1; s.pend = 16'h0888;
    drive("R4 external over software/timer", s, m_trap(s, 1, 32'h8000_000B, 32'h3000, 0));
    s = base(); s.m_ie = 1; s.pend = 16'h00A8;
    drive("R4 software over timer", s, m_trap(s, 1, 32'h8000_0003, 32'h3000, 0));
    s = base(); s.m_ie = 1; s.pend = 16'h2800;
    drive("R4 high lines over external", s, m_trap(s, 1, 32'h8000_000D, 32'h3000, 0));
    s = base(); s.m_ie = 1; s.pend = 16'h5800;
    drive("R4 lowest high line", s, m_trap(s, 1, 32'h8000_000C, 32'h3000, 0));
    s = base(); s.m_ie = 1; s.pend = 16'h0555;
    drive("R4 even lines ignored", s, idle(s));
    s = base(); s.m_ie = 1; s.pend = 16'h0575;
    drive("R4 R5 timer among ignored", s, m_trap(s, 1, 32'h8000_0005, 32'h3000, 0));

    // R3 R8 R9 delegation
    s = base(); s.priv = 2'd1; s.s_ie = 1; s.ideleg = 16'h0020; s.pend = 16'h0020;
    s.m_ie = 1; s.m_pie = 0;
    drive("R3 R8 R9 delegated from S", s, s_trap(s, 1, 32'h8000_0005, 32'h2000, 0));
    s = base(); s.priv = 2'd1; s.s_ie = 0; s.ideleg = 16'h0020; s.pend = 16'h0020;
    drive("R3 S-level, SIE off", s, idle(s));
    s = base(); s.priv = 2'd3; s.s_ie = 1; s.m_ie = 1; s.ideleg = 16'h0020; s.pend = 16'h0020;
    drive("R3 delegated never in M", s, idle(s));
    s = base(); s.priv = 2'd0; s.ideleg = 16'h0020; s.pend = 16'h0020; s.s_pie = 1;
    drive("R3 R9 delegated from U", s, s_trap(s, 1, 32'h8000_0005, 32'h2000, 0));
    s = base(); s.priv = 2'd0; s.ideleg = 16'h0200; s.pend = 16'h0280;
    drive("R3 machine group before delegated", s, m_trap(s, 1, 32'h8000_0007, 32'h3000, 0));

    // R6 debug
    s = base(); s.m_ie = 1; s.pend = 16'h0080; s.dbg = 1;
    drive("R6 debug blocks irq", s, idle(s));
    s = base(); s.m_ie = 1; s.pend = 16'h0080; s.dbg = 1; s.exc = 1;
    s.ecause = 32'd3; s.etval = 32'h77;
    drive("R6 debug keeps exceptions", s, m_trap(s, 0, 32'd3, 32'h3000, 32'h77));

    // R7 R11 exceptions
    s = base(); s.mvec = 32'h3001; s.exc = 1; s.ecause = 32'd2; s.etval = 32'hDEAD;
    drive("R7 R11 exception not vectored", s, m_trap(s, 0, 32'd2, 32'h3000, 32'hDEAD));
    s = base(); s.priv = 2'd0; s.exc = 1; s.ecause = 32'd8; s.edeleg = 32'h100; s.etval = 32'h12;
    drive("R8 exception delegated from U", s, s_trap(s, 0, 32'd8, 32'h2000, 32'h12));
    s = base(); s.priv = 2'd3; s.exc = 1; s.ecause = 32'd8; s.edeleg = 32'h100;
    drive("R8 exception in M stays M", s, m_trap(s, 0, 32'd8, 32'h3000, 0));
    s = base(); s.priv = 2'd0; s.exc = 1; s.ecause = 32'd40; s.edeleg = 32'hFFFF_FFFF;
    drive("R8 cause beyond XLEN not delegated", s, m_trap(s, 0, 32'd40, 32'h3000, 0));
    s = base(); s.priv = 2'd1; s.exc = 1; s.ecause = 32'd8; s.edeleg = 32'h0;
    drive("R8 undelegated from S", s, m_trap(s, 0, 32'd8, 32'h3000, 0));

    // R11 vectored, R9 S vector untouched
    s = base(); s.m_ie = 1; s.mvec = 32'h3001; s.pend = 16'h0080;
    drive("R11 vectored timer", s, m_trap(s, 1, 32'h8000_0007, 32'h301C, 0));
    s = base(); s.m_ie = 1; s.mvec = 32'h3001; s.pend = 16'h2000;
    drive("R11 vectored high line", s, m_trap(s, 1, 32'h8000_000D, 32'h3034, 0));
    s = base(); s.priv = 2'd1; s.s_ie = 1; s.svec = 32'h2001; s.ideleg = 16'h0002; s.pend = 16'h0002;
    drive("R9 S vector used as is", s, s_trap(s, 1, 32'h8000_0001, 32'h2001, 0));

    // R7 interrupt and exception together
    s = base(); s.m_ie = 1; s.mvec = 32'h3001; s.pend = 16'h0800;
    s.exc = 1; s.ecause = 32'd5; s.etval = 32'h55;
    drive("R7 interrupt wins over exception", s, m_trap(s, 1, 32'h8000_000B, 32'h302C, 0));

    s = base();
    drive("R1 idle at end", s, idle(s));

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule